// File: doc/BRIEF.md
# Single-Outstanding Interrupt Vector Dispatcher

The dispatcher gathers 64 level-sensitive interrupt lines and hands the CPU one interrupt number at a time. Lines 0 to 31 come from PCI slots. They are gated in groups of four: line i obeys the enable of PCI mapping entry i>>2. Lines 32 to 63 come from on-board I/O, and each has a mapping entry of its own. A request, once presented, stays outstanding until software acknowledges it through a clear register or disables the matching mapping entry. Only then does a new priority scan run.

Software reaches the mapping entries and clear registers over a plain 32-bit register bus. That bus has an address, a write strobe, write data, and combinational read data. Each entry takes 8 bytes, and only the word at address bit 2 = 1 is live. The address windows are:

- PCI mapping entries 0xC00-0xC3F, entry index addr[5:3].
- Board mapping entries 0x1000-0x10FF, entry index addr[7:3].
- PCI clear 0x1400-0x14FF, group addr[7:5].
- Board clear 0x1800-0x1860, source 32 + addr[7:3].

The request and the vector number are registered. An input edge or a register write takes effect at the following clock edge.

Top module: `irqd_dispatch`

## Requirements
- R1: After reset `req_valid` is 0 and `req_vec` is 0 (idle), every enable bit reads 0, and the level register is emptied.
- R2: A mapping entry reads as {enable, 31-bit constant}. The constant is 0x7C0 | (i<<2) for PCI entry i and 0x7E0 + i for board entry i. A write changes only bit 31. The word with address bit 2 = 0 reads 0, and writes to it change nothing.
- R3: When a PCI line rises while its group is enabled, it becomes the request at the next edge, replacing any outstanding request. If several such lines rise together, the lowest wins.
- R4: A rising board line becomes the request only if no request is outstanding and its entry is enabled.
- R5: Every mapping write, and every clear that drops the request, triggers a rescan. The rescan keeps an outstanding request unchanged. Otherwise it picks the lowest-numbered asserted and enabled line, so PCI lines win over board lines.
- R6: A PCI clear write with group g drops the request only when request/4 equals g; the drop is followed by a rescan.
- R7: A board clear write at source 32+k drops the request only when the request equals 32+k; the drop is followed by a rescan.
- R8: A mapping write with bit 31 = 0 drops the request when the request number equals the entry's number. For PCI entry i that number is i; for board entry k it is 32+k.
- R9: A falling input line does not withdraw an outstanding request.
- R10: A rising line whose mapping entry is disabled never becomes a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lvl | input | 64 | Interrupt levels; [31:0] PCI, [63:32] board |
| reg_addr | input | 16 | Register byte address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| req_valid | output | 1 | A request is outstanding |
| req_vec | output | 6 | Outstanding interrupt number |

## Verification
The assertions assume that each write is a single-cycle strobe with a stable address. They also assume that interrupt lines change only between clock edges, because a rise is defined against the previous cycle's sampled level. The stimulus changes lines and issues writes on separate cycles, and drives everything at the falling edge. No input edge therefore coincides with a write, and the predicted request follows from one cause per cycle.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    // Fixed source architecture of the dispatcher
    localparam int NUM_PCI_SRC = 32;
    localparam int PCI_PER_GRP = 4;
    localparam int NUM_PCI_MAP = NUM_PCI_SRC / PCI_PER_GRP;
    localparam int NUM_BRD_SRC = 32;
    localparam int NUM_SRC     = NUM_PCI_SRC + NUM_BRD_SRC;
    localparam int VEC_W       = $clog2(NUM_SRC);
    localparam int REQ_W       = VEC_W + 1;
    localparam int IDX_W       = $clog2(NUM_BRD_SRC);
    localparam int PGRP_W      = $clog2(NUM_PCI_MAP);

    // Request encoding: MSB set means no request outstanding
    localparam logic [REQ_W-1:0] REQ_NONE = REQ_W'(NUM_SRC);

    // Decoded register access, live word only (address bit 2 = 1)
    typedef struct packed {
        logic             pci_map;
        logic             brd_map;
        logic             pci_clr;
        logic             brd_clr;
        logic [IDX_W-1:0] idx;
        logic             en;
    } reg_ev_t;

    // Constant low field of PCI mapping entry i
    function automatic logic [30:0] pci_map_low(input int i);
        return 31'(11'h7C0 | 11'(i << 2));
    endfunction

    // Constant low field of board mapping entry i
    function automatic logic [30:0] brd_map_low(input int i);
        return 31'(11'h7E0 + 11'(i));
    endfunction

    // Index of the lowest set bit (0 when none is set)
    function automatic logic [VEC_W-1:0] lowest_set(input logic [NUM_SRC-1:0] v);
        logic [VEC_W-1:0] r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = VEC_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqd_bus_decode.sv
// Register bus decoder.
// Turns a byte address into one of four access kinds plus an index. Only
// the word at address bit 2 = 1 of each 8-byte entry is decoded; the other
// word matches nothing. Assumes ADDR_W >= 16.
module irqd_bus_decode
    import irqd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PCI_MAP_BASE = 'h0C00,
    parameter logic [ADDR_W-1:0] BRD_MAP_BASE = 'h1000,
    parameter logic [ADDR_W-1:0] PCI_CLR_BASE = 'h1400,
    parameter logic [ADDR_W-1:0] PCI_CLR_LAST = 'h14FF,
    parameter logic [ADDR_W-1:0] BRD_CLR_BASE = 'h1800,
    parameter logic [ADDR_W-1:0] BRD_CLR_LAST = 'h1860
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              wbit,
    output reg_ev_t           acc,
    output reg_ev_t           wr
);
    localparam logic [ADDR_W-1:0] PCI_MAP_LAST = PCI_MAP_BASE + ADDR_W'(NUM_PCI_MAP * 8 - 1);
    localparam logic [ADDR_W-1:0] BRD_MAP_LAST = BRD_MAP_BASE + ADDR_W'(NUM_BRD_SRC * 8 - 1);

    logic live;
    assign live = addr[2];

    // Window match and index extraction for the addressed entry
    always_comb begin
        acc = '0;
        acc.en = wbit;
        if (live && addr >= PCI_MAP_BASE && addr <= PCI_MAP_LAST) begin
            acc.pci_map = 1'b1;
            acc.idx     = IDX_W'(addr[5:3]);
        end
        if (live && addr >= BRD_MAP_BASE && addr <= BRD_MAP_LAST) begin
            acc.brd_map = 1'b1;
            acc.idx     = addr[7:3];
        end
        if (live && addr >= PCI_CLR_BASE && addr <= PCI_CLR_LAST) begin
            acc.pci_clr = 1'b1;
            acc.idx     = IDX_W'(addr[7:5]);
        end
        if (live && addr >= BRD_CLR_BASE && addr <= BRD_CLR_LAST) begin
            acc.brd_clr = 1'b1;
            acc.idx     = addr[7:3];
        end
    end

    // Write events are the access qualified by the strobe
    always_comb begin
        wr         = acc;
        wr.pci_map = acc.pci_map & we;
        wr.brd_map = acc.brd_map & we;
        wr.pci_clr = acc.pci_clr & we;
        wr.brd_clr = acc.brd_clr & we;
    end
endmodule

// File: rtl/irqd_map_regs.sv
// Mapping entries.
// Holds one enable flop per PCI group and per board source. The low 31
// bits of every entry are constants, so only the enables are storage.
// Provides next-cycle enables so a same-cycle rescan sees a write.
module irqd_map_regs
    import irqd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  reg_ev_t                acc,
    input  reg_ev_t                wr,
    output logic [NUM_PCI_MAP-1:0] pci_en_nx,
    output logic [NUM_BRD_SRC-1:0] brd_en_nx,
    output logic [DATA_W-1:0]      rdata
);
    logic [NUM_PCI_MAP-1:0] pci_en_q;
    logic [NUM_BRD_SRC-1:0] brd_en_q;

    // Per-entry enable storage for the PCI groups
    for (genvar g = 0; g < NUM_PCI_MAP; g++) begin : g_pci
        assign pci_en_nx[g] = (wr.pci_map && wr.idx == IDX_W'(g)) ? wr.en : pci_en_q[g];
        always_ff @(posedge clk) begin
            // Enable flop, cleared on reset
            if (!rst_n) pci_en_q[g] <= 1'b0;
            else        pci_en_q[g] <= pci_en_nx[g];
        end
    end

    // Per-entry enable storage for the board sources
    for (genvar k = 0; k < NUM_BRD_SRC; k++) begin : g_brd
        assign brd_en_nx[k] = (wr.brd_map && wr.idx == IDX_W'(k)) ? wr.en : brd_en_q[k];
        always_ff @(posedge clk) begin
            // Enable flop, cleared on reset
            if (!rst_n) brd_en_q[k] <= 1'b0;
            else        brd_en_q[k] <= brd_en_nx[k];
        end
    end

    // Read mux: enable plus constant field, zero elsewhere
    always_comb begin
        rdata = '0;
        if (acc.pci_map) begin
            for (int g = 0; g < NUM_PCI_MAP; g++) begin
                if (acc.idx == IDX_W'(g)) rdata = DATA_W'({pci_en_q[g], pci_map_low(g)});
            end
        end else if (acc.brd_map) begin
            for (int k = 0; k < NUM_BRD_SRC; k++) begin
                if (acc.idx == IDX_W'(k)) rdata = DATA_W'({brd_en_q[k], brd_map_low(k)});
            end
        end
    end
endmodule

// File: rtl/irqd_level_track.sv
// Level tracker.
// Samples the interrupt lines every clock and reports the lines that
// are high now but were low at the previous sample. Assumes the lines
// are synchronous to clk.
module irqd_level_track
    import irqd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl_in,
    output logic [NUM_SRC-1:0] lvl_q,
    output logic [NUM_SRC-1:0] rise
);
    // Sampled level register, emptied on reset
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_in;
    end

    assign rise = lvl_in & ~lvl_q;
endmodule

// File: rtl/irqd_request_ctrl.sv
// Request controller.
// Owns the single outstanding request. In one cycle it applies the
// register writes (drop on disable or clear), then rescans if needed,
// then lets an enabled PCI rise override and an enabled board rise fill
// an empty slot. Assumes at most one register event per cycle.
module irqd_request_ctrl
    import irqd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  reg_ev_t                wr,
    input  logic [NUM_SRC-1:0]     lvl_q,
    input  logic [NUM_SRC-1:0]     rise,
    input  logic [NUM_PCI_MAP-1:0] pci_en,
    input  logic [NUM_BRD_SRC-1:0] brd_en,
    output logic [REQ_W-1:0]       req_q
);
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] pci_rise;
    logic [NUM_SRC-1:0] brd_rise;
    logic [REQ_W-1:0]   req_nx;
    logic               rescan;
    logic [REQ_W-1:0]   brd_hit;

    // Per-line enable: PCI lines share their group enable
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        if (i < NUM_PCI_SRC) begin : g_p
            assign src_en[i] = pci_en[i / PCI_PER_GRP];
        end else begin : g_b
            assign src_en[i] = brd_en[i - NUM_PCI_SRC];
        end
    end

    assign pend     = lvl_q & src_en;
    assign pci_rise = rise & src_en & {{NUM_BRD_SRC{1'b0}}, {NUM_PCI_SRC{1'b1}}};
    assign brd_rise = rise & src_en & {{NUM_BRD_SRC{1'b1}}, {NUM_PCI_SRC{1'b0}}};
    assign brd_hit  = REQ_W'(NUM_PCI_SRC) + REQ_W'(wr.idx);

    // Next request: writes, then rescan, then input edges
    always_comb begin
        req_nx = req_q;
        rescan = 1'b0;
        if (wr.pci_map) begin
            if (!wr.en && req_q == REQ_W'(wr.idx)) req_nx = REQ_NONE;
            rescan = 1'b1;
        end
        if (wr.brd_map) begin
            if (!wr.en && req_q == brd_hit) req_nx = REQ_NONE;
            rescan = 1'b1;
        end
        if (wr.pci_clr && req_q < REQ_W'(NUM_PCI_SRC)
            && (req_q / REQ_W'(PCI_PER_GRP)) == REQ_W'(wr.idx)) begin
            req_nx = REQ_NONE;
            rescan = 1'b1;
        end
        if (wr.brd_clr && req_q == brd_hit) begin
            req_nx = REQ_NONE;
            rescan = 1'b1;
        end
        if (rescan && req_nx == REQ_NONE && |pend) begin
            req_nx = {1'b0, lowest_set(pend)};
        end
        if (|pci_rise) begin
            req_nx = {1'b0, lowest_set(pci_rise)};
        end else if (req_nx == REQ_NONE && |brd_rise) begin
            req_nx = {1'b0, lowest_set(brd_rise)};
        end
    end

    // Outstanding request register, idle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= REQ_NONE;
        else        req_q <= req_nx;
    end
endmodule

// File: rtl/irqd_dispatch.sv
// Single-outstanding interrupt vector dispatcher, top level.
// Wires the decoder, mapping entries, level tracker and request
// controller. Assumes single-cycle write strobes and synchronous lines.
module irqd_dispatch
    import irqd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_lvl,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               req_valid,
    output logic [VEC_W-1:0]   req_vec
);
    reg_ev_t                acc;
    reg_ev_t                wr;
    logic [NUM_PCI_MAP-1:0] pci_en_nx;
    logic [NUM_BRD_SRC-1:0] brd_en_nx;
    logic [NUM_SRC-1:0]     lvl_q;
    logic [NUM_SRC-1:0]     lvl_rise;
    logic [REQ_W-1:0]       req_q;

    irqd_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .we   (reg_we),
        .wbit (reg_wdata[31]),
        .acc  (acc),
        .wr   (wr)
    );

    irqd_map_regs #(.DATA_W(DATA_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .wr        (wr),
        .pci_en_nx (pci_en_nx),
        .brd_en_nx (brd_en_nx),
        .rdata     (reg_rdata)
    );

    irqd_level_track u_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (irq_lvl),
        .lvl_q  (lvl_q),
        .rise   (lvl_rise)
    );

    irqd_request_ctrl u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr),
        .lvl_q  (lvl_q),
        .rise   (lvl_rise),
        .pci_en (pci_en_nx),
        .brd_en (brd_en_nx),
        .req_q  (req_q)
    );

    assign req_valid = (req_q != REQ_NONE);
    assign req_vec   = req_q[VEC_W-1:0];
endmodule

// File: rtl/irqd_checker.sv
// Property checker for the dispatcher, attached by bind.
// Assumes single-cycle write strobes; observes the ports plus the
// rising-edge and next-enable signals from the internal blocks.
module irqd_checker
    import irqd_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [15:0]            reg_addr,
    input logic                   reg_we,
    input logic [31:0]            reg_wdata,
    input logic                   req_valid,
    input logic [VEC_W-1:0]       req_vec,
    input logic [NUM_SRC-1:0]     rise,
    input logic [NUM_PCI_MAP-1:0] pci_en
);
    logic [NUM_PCI_SRC-1:0] pci_take;
    logic                   any_pci_take;
    logic                   brd_disable_hit;

    for (genvar i = 0; i < NUM_PCI_SRC; i++) begin : g_t
        assign pci_take[i] = rise[i] & pci_en[i / PCI_PER_GRP];
    end
    assign any_pci_take = |pci_take;

    assign brd_disable_hit = reg_we && reg_addr[2] && reg_addr >= 16'h1000
                          && reg_addr <= 16'h10FF && !reg_wdata[31] && req_valid
                          && req_vec == {1'b1, reg_addr[7:3]};

    // R1: idle in the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !req_valid);

    // R3: an enabled PCI rise always yields a PCI request
    a_r3_pci_take: assert property (@(posedge clk) disable iff (!rst_n)
        any_pci_take |=> (req_valid && !req_vec[5]));

    // R4 and R9: without writes or enabled PCI rises the request holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !reg_we && !any_pci_take) |=> (req_valid && $stable(req_vec)));

    // R8: disabling the matching board entry removes that request
    a_r8_board_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_disable_hit && !any_pci_take) |=> !(req_valid && req_vec == $past(req_vec)));
endmodule

bind irqd_dispatch irqd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .req_valid (req_valid),
    .req_vec   (req_vec),
    .rise      (lvl_rise),
    .pci_en    (pci_en_nx)
);

// File: tb/sim_irqd_dispatch.sv
module sim_irqd_dispatch;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq = '0;
    logic [15:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        req_valid;
    logic [5:0]  req_vec;
    int          n_chk = 0;
    int          n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irqd_dispatch u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lvl   (irq),
        .reg_addr  (addr),
        .reg_we    (we),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .req_valid (req_valid),
        .req_vec   (req_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Request check: idle encodes as valid 0, vector 0
    task automatic chk_req(input string tag, input logic v, input logic [5:0] vec);
        chk(tag, {25'b0, req_valid, req_vec}, {25'b0, v, vec});
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_line(input int n, input logic v);
        @(negedge clk);
        irq[n] = v;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        chk_req("R1 idle after reset", 1'b0, 6'd0);
        rd_reg(16'h0C04, d); chk("R1 pci entry 0", d, 32'h0000_07C0);
        rd_reg(16'h0C3C, d); chk("R2 pci entry 7 constant", d, 32'h0000_07DC);
        rd_reg(16'h102C, d); chk("R2 board entry 5 constant", d, 32'h0000_07E5);
        rd_reg(16'h0C00, d); chk("R2 dead word reads zero", d, 32'h0);
    endtask

    task automatic t_map_write();
        logic [31:0] d;
        wr_reg(16'h0C0C, 32'h8000_1234);
        rd_reg(16'h0C0C, d); chk("R2 only bit 31 written", d, 32'h8000_07C4);
        wr_reg(16'h0C08, 32'h0);
        rd_reg(16'h0C0C, d); chk("R2 dead word write ignored", d, 32'h8000_07C4);
    endtask

    task automatic t_disabled_line();
        set_line(1, 1'b1);
        chk_req("R10 disabled pci line ignored", 1'b0, 6'd0);
        set_line(1, 1'b0);
    endtask

    task automatic t_pci_override();
        set_line(6, 1'b1);
        chk_req("R3 pci rise taken", 1'b1, 6'd6);
        wr_reg(16'h101C, 32'h8000_0000);
        chk_req("R5 rescan keeps outstanding", 1'b1, 6'd6);
        set_line(35, 1'b1);
        chk_req("R4 board rise blocked", 1'b1, 6'd6);
        set_line(5, 1'b1);
        chk_req("R3 pci rise overrides", 1'b1, 6'd5);
        set_line(5, 1'b0);
        chk_req("R9 fall keeps request", 1'b1, 6'd5);
    endtask

    task automatic t_pci_clear();
        wr_reg(16'h1404, 32'h0);
        chk_req("R6 other group no effect", 1'b1, 6'd5);
        wr_reg(16'h1424, 32'h0);
        chk_req("R6 clear then rescan", 1'b1, 6'd6);
        set_line(6, 1'b0);
        wr_reg(16'h1424, 32'h0);
        chk_req("R5 rescan reaches board", 1'b1, 6'd35);
    endtask

    task automatic t_board_clear();
        set_line(35, 1'b0);
        wr_reg(16'h1814, 32'h0);
        chk_req("R7 other source no effect", 1'b1, 6'd35);
        wr_reg(16'h181C, 32'h0);
        chk_req("R7 matching clear drops", 1'b0, 6'd0);
    endtask

    task automatic t_priority();
        set_line(40, 1'b1);
        chk_req("R10 disabled board line ignored", 1'b0, 6'd0);
        set_line(12, 1'b1);
        chk_req("R10 disabled group ignored", 1'b0, 6'd0);
        wr_reg(16'h1044, 32'h8000_0000);
        chk_req("R5 enable write rescans", 1'b1, 6'd40);
        wr_reg(16'h0C1C, 32'h8000_0000);
        chk_req("R5 outstanding held on write", 1'b1, 6'd40);
        wr_reg(16'h1844, 32'h0);
        chk_req("R5 pci wins rescan", 1'b1, 6'd12);
    endtask

    task automatic t_disable_drop();
        set_line(12, 1'b0);
        wr_reg(16'h1464, 32'h0);
        chk_req("R6 group 3 clear", 1'b1, 6'd40);
        wr_reg(16'h1044, 32'h0);
        chk_req("R8 disable drops request", 1'b0, 6'd0);
    endtask

    task automatic t_reset_again();
        logic [31:0] d;
        set_line(13, 1'b1);
        chk_req("R3 request before reset", 1'b1, 6'd13);
        do_reset();
        chk_req("R1 reset drops request", 1'b0, 6'd0);
        rd_reg(16'h0C1C, d); chk("R1 reset clears enable", d, 32'h0000_07CC);
        set_line(13, 1'b0);
        irq = '0;
    endtask

    bit done = 0;

    initial begin
        t_reset_state();
        t_map_write();
        t_disabled_line();
        t_pci_override();
        t_pci_clear();
        t_board_clear();
        t_priority();
        t_disable_drop();
        t_reset_again();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule